// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block owns the machine-mode trap state of a processor hart: the interrupt-enable stack in the status register, the saved exception program counter, the cause register and the trap value register. When the pipeline raises a trap request, the controller saves the faulting or resume address, records why the trap happened and where it came from, masks interrupts and produces the handler address from the trap-vector register. When the pipeline issues a machine return, the controller unwinds the interrupt-enable and privilege stack and hands back the saved address.

The same block also reduces the pending and enabled interrupt lines to a single request with a fixed priority, gated by the global machine interrupt enable. The pipeline uses this request to decide when to inject an interrupt trap. Detecting exceptions, delegating traps to lower modes and the interrupt sources themselves all stay outside. The redirect address and the new privilege are combinational in the cycle of the request. The stored state changes at the next clock edge.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset, global enable and previous enable read 0, the previous privilege reads 3 (machine), and the saved PC, cause and trap value read 0.
- R2: On a clock edge with trap_req high, the previous enable takes the old global enable, the global enable clears and the previous privilege takes cur_priv. While trap_req is high, priv_out is 3.
- R3: On a trap, the cause register gets bit XLEN-1 equal to trap_is_irq and trap_cause zero-extended into the low bits.
- R4: On a trap, the saved PC gets trap_pc with bit 0 forced to 0.
- R5: On a trap, the trap value register gets trap_val for exceptions (trap_is_irq low) and 0 for interrupts.
- R6: Mode is mtvec[1:0] and base is mtvec with bits 1:0 cleared. In mode 1, an interrupt redirects to base + 4 × trap_cause. Exceptions in mode 1, and all traps in mode 0 or in the reserved modes 2 and 3, redirect to base. redirect_valid is high in any cycle with trap_req or mret.
- R7: With mret high and no trap, redirect_pc is the saved PC and priv_out is the previous privilege. At the edge, the global enable takes the previous enable, the previous enable becomes 1 and the previous privilege becomes 0 (user).
- R8: When trap_req and mret are high together, the trap is taken and the return is ignored.
- R9: irq_take is high exactly when the global enable is 1 and at least one of bit positions 3 (software), 7 (timer) or 11 (external) is set in both irq_pend and irq_en. All other bit positions have no effect.
- R10: While irq_take is high, irq_code names the winning source. External (11) beats software (3), and software beats timer (7).
- R11: In a cycle with neither trap_req nor mret, redirect_valid is low, priv_out equals cur_priv and all stored state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_is_irq | input | 1 | Trap is an interrupt (1) or an exception (0) |
| trap_cause | input | CAUSE_W | Cause code of the trap |
| trap_val | input | XLEN | Diagnostic value for exceptions |
| trap_pc | input | XLEN | PC of the faulting instruction or of the next instruction |
| cur_priv | input | 2 | Privilege level the hart currently runs at |
| mret | input | 1 | Machine return strobe |
| mtvec | input | XLEN | Trap vector register: base in the upper bits, mode in bits 1:0 |
| irq_pend | input | XLEN | Interrupt pending bits |
| irq_en | input | XLEN | Interrupt enable bits |
| redirect_valid | output | 1 | Fetch must redirect this cycle |
| redirect_pc | output | XLEN | Handler or return address |
| priv_out | output | 2 | Privilege level to run at after this cycle |
| stat_mie | output | 1 | Global machine interrupt enable |
| stat_mpie | output | 1 | Previous interrupt enable |
| stat_mpp | output | 2 | Previous privilege |
| epc_q | output | XLEN | Saved exception PC |
| cause_q | output | XLEN | Trap cause register |
| tval_q | output | XLEN | Trap value register |
| irq_take | output | 1 | An enabled interrupt is pending and globally allowed |
| irq_code | output | CAUSE_W | Cause code of the winning interrupt |

## Verification
On every clock edge, the assertions check the stack swap on entry and return, the interrupt and cause bit in the cause register, the even saved PC, the hold of state in idle cycles, that a return redirects to the saved PC, that an interrupt request never appears while the global enable is clear, and that the external source always wins. Some behaviour can be shown only by the bench's scenarios, where a reference model runs beside the design: the handler addresses for each vector mode, including the reserved ones, the zeroing of the trap value for interrupts, the software-over-timer ordering, the bits outside the three interrupt positions being ignored, and the collision of a return with a trap.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam int NUM_IRQ_SRC = 3;
   // interrupt bit positions ordered from highest to lowest priority
   localparam int IRQ_POS_EXT = 11;
   localparam int IRQ_POS_SW  = 3;
   localparam int IRQ_POS_TMR = 7;

   localparam logic [1:0] VEC_DIRECT = 2'd0;
   localparam logic [1:0] VEC_TABLE  = 2'd1;

   typedef struct packed {
      logic       gie;
      logic       pie;
      logic [1:0] ppriv;
   } irq_stack_t;

   function automatic int irq_pos(input int rank);
      case (rank)
         0:       return IRQ_POS_EXT;
         1:       return IRQ_POS_SW;
         default: return IRQ_POS_TMR;
      endcase
   endfunction

endpackage

// File: rtl/mtrap_irq_arb.sv
module mtrap_irq_arb
   import mtrap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5
) (
   input  logic [XLEN-1:0]    pend,
   input  logic [XLEN-1:0]    en,
   input  logic               gie,
   output logic               take,
   output logic [CAUSE_W-1:0] code
);

   localparam int MAX_POS = IRQ_POS_EXT;

   if (XLEN <= MAX_POS) begin : g_bad_xlen
      $error("mtrap_irq_arb: XLEN too small for interrupt positions");
   end
   if ((1 << CAUSE_W) <= MAX_POS) begin : g_bad_cw
      $error("mtrap_irq_arb: CAUSE_W too small for interrupt codes");
   end

   logic [NUM_IRQ_SRC-1:0] hit;

   for (genvar r = 0; r < NUM_IRQ_SRC; r++) begin : g_src
      localparam int POS = irq_pos(r);
      assign hit[r] = pend[POS] & en[POS];
   end

   always_comb begin
      code = CAUSE_W'(irq_pos(NUM_IRQ_SRC - 1));
      for (int r = NUM_IRQ_SRC - 1; r >= 0; r--) begin
         if (hit[r]) code = CAUSE_W'(irq_pos(r));
      end
   end

   assign take = gie & (|hit);

endmodule

// File: rtl/mtrap_target.sv
module mtrap_target
   import mtrap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5,
   parameter bit VEC_EN  = 1'b1
) (
   input  logic [XLEN-1:0]    tvec,
   input  logic               is_irq,
   input  logic [CAUSE_W-1:0] cause,
   output logic [XLEN-1:0]    target
);

   localparam int OFS_W = CAUSE_W + 2;

   if (OFS_W >= XLEN) begin : g_bad_ofs
      $error("mtrap_target: vector offset wider than XLEN");
   end

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   assign base   = {tvec[XLEN-1:2], 2'b00};
   assign offset = XLEN'({cause, 2'b00});

   if (VEC_EN) begin : g_vectored
      always_comb begin
         if (tvec[1:0] == VEC_TABLE && is_irq) target = base + offset;
         else                                  target = base;
      end
   end else begin : g_direct_only
      logic unused_ok;
      assign unused_ok = &{1'b0, is_irq, offset};
      assign target    = base;
   end

endmodule

// File: rtl/mtrap_state.sv
module mtrap_state
   import mtrap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_req,
   input  logic               trap_is_irq,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [XLEN-1:0]    trap_val,
   input  logic [XLEN-1:0]    trap_pc,
   input  logic [1:0]         cur_priv,
   input  logic               mret,
   output irq_stack_t         stk,
   output logic [XLEN-1:0]    epc,
   output logic [XLEN-1:0]    cause,
   output logic [XLEN-1:0]    tval
);

   localparam int PAD_W = XLEN - 1 - CAUSE_W;

   if (PAD_W < 1) begin : g_bad_pad
      $error("mtrap_state: CAUSE_W must leave room below the interrupt flag");
   end

   irq_stack_t stk_nxt;

   always_comb begin
      stk_nxt = stk;
      if (trap_req) begin
         stk_nxt.pie   = stk.gie;
         stk_nxt.gie   = 1'b0;
         stk_nxt.ppriv = cur_priv;
      end else if (mret) begin
         stk_nxt.gie   = stk.pie;
         stk_nxt.pie   = 1'b1;
         stk_nxt.ppriv = PRIV_U;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stk   <= '{gie: 1'b0, pie: 1'b0, ppriv: PRIV_M};
         epc   <= '0;
         cause <= '0;
         tval  <= '0;
      end else begin
         stk <= stk_nxt;
         if (trap_req) begin
            epc   <= {trap_pc[XLEN-1:1], 1'b0};
            cause <= {trap_is_irq, {PAD_W{1'b0}}, trap_cause};
            tval  <= trap_is_irq ? '0 : trap_val;
         end
      end
   end

   // R2
   trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (!stk.gie && stk.pie == $past(stk.gie) && stk.ppriv == $past(cur_priv)));

   // R7
   mret_unwind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mret && !trap_req) |=> (stk.gie == $past(stk.pie) && stk.pie && stk.ppriv == PRIV_U));

   // R4
   epc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (epc == ($past(trap_pc) & ~XLEN'(1))));

   // R3
   cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (cause[XLEN-1] == $past(trap_is_irq)));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_req && !mret) |=> ($stable(stk) && $stable(epc) && $stable(cause) && $stable(tval)));

endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
   import mtrap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5,
   parameter bit VEC_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_req,
   input  logic               trap_is_irq,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [XLEN-1:0]    trap_val,
   input  logic [XLEN-1:0]    trap_pc,
   input  logic [1:0]         cur_priv,
   input  logic               mret,
   input  logic [XLEN-1:0]    mtvec,
   input  logic [XLEN-1:0]    irq_pend,
   input  logic [XLEN-1:0]    irq_en,
   output logic               redirect_valid,
   output logic [XLEN-1:0]    redirect_pc,
   output logic [1:0]         priv_out,
   output logic               stat_mie,
   output logic               stat_mpie,
   output logic [1:0]         stat_mpp,
   output logic [XLEN-1:0]    epc_q,
   output logic [XLEN-1:0]    cause_q,
   output logic [XLEN-1:0]    tval_q,
   output logic               irq_take,
   output logic [CAUSE_W-1:0] irq_code
);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("mtrap_ctrl: XLEN must be 32 or 64");
   end

   irq_stack_t      stk;
   logic [XLEN-1:0] handler_pc;

   mtrap_state #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .trap_req    (trap_req),
      .trap_is_irq (trap_is_irq),
      .trap_cause  (trap_cause),
      .trap_val    (trap_val),
      .trap_pc     (trap_pc),
      .cur_priv    (cur_priv),
      .mret        (mret),
      .stk         (stk),
      .epc         (epc_q),
      .cause       (cause_q),
      .tval        (tval_q)
   );

   mtrap_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_EN(VEC_EN)) u_target (
      .tvec   (mtvec),
      .is_irq (trap_is_irq),
      .cause  (trap_cause),
      .target (handler_pc)
   );

   mtrap_irq_arb #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_arb (
      .pend (irq_pend),
      .en   (irq_en),
      .gie  (stk.gie),
      .take (irq_take),
      .code (irq_code)
   );

   assign stat_mie       = stk.gie;
   assign stat_mpie      = stk.pie;
   assign stat_mpp       = stk.ppriv;
   assign redirect_valid = trap_req | mret;

   always_comb begin
      if (trap_req) begin
         redirect_pc = handler_pc;
         priv_out    = PRIV_M;
      end else if (mret) begin
         redirect_pc = epc_q;
         priv_out    = stk.ppriv;
      end else begin
         redirect_pc = handler_pc;
         priv_out    = cur_priv;
      end
   end

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (stat_mie && (|(irq_pend & irq_en))));

   // R10
   ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && irq_pend[IRQ_POS_EXT] && irq_en[IRQ_POS_EXT]) |-> (irq_code == CAUSE_W'(IRQ_POS_EXT)));

   // R7
   mret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mret && !trap_req) |-> (redirect_valid && redirect_pc == epc_q && priv_out == stat_mpp));

   // R2
   trap_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (redirect_valid && priv_out == PRIV_M));

endmodule

// File: tb/mtrap_ctrl_test.sv
module mtrap_ctrl_test;

   localparam int XLEN    = 32;
   localparam int CAUSE_W = 5;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               trap_req, trap_is_irq, mret;
   logic [CAUSE_W-1:0] trap_cause;
   logic [XLEN-1:0]    trap_val, trap_pc, mtvec, irq_pend, irq_en;
   logic [1:0]         cur_priv;
   logic               redirect_valid, stat_mie, stat_mpie, irq_take;
   logic [XLEN-1:0]    redirect_pc, epc_q, cause_q, tval_q;
   logic [1:0]         priv_out, stat_mpp;
   logic [CAUSE_W-1:0] irq_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   bit          m_mie, m_mpie;
   logic [1:0]  m_mpp;
   logic [31:0] m_epc, m_cause, m_tval;
   string       last_tag;

   always #2.5 clk = ~clk;

   mtrap_ctrl #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) uut (.*);

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      logic [31:0] act_en, base, exp_pc;
      bit          hit_e, hit_s, hit_t, exp_take;
      int          exp_code;
      string       t_now;
      // stored state, tagged by what the previous edge did
      chk(stat_mie  == m_mie,  last_tag, "mie",  32'(stat_mie),  32'(m_mie));
      chk(stat_mpie == m_mpie, last_tag, "mpie", 32'(stat_mpie), 32'(m_mpie));
      chk(stat_mpp  == m_mpp,  last_tag, "mpp",  32'(stat_mpp),  32'(m_mpp));
      chk(epc_q   == m_epc,   (last_tag == "R2") ? "R4" : last_tag, "epc",   epc_q,   m_epc);
      chk(cause_q == m_cause, (last_tag == "R2") ? "R3" : last_tag, "cause", cause_q, m_cause);
      chk(tval_q  == m_tval,  (last_tag == "R2") ? "R5" : last_tag, "tval",  tval_q,  m_tval);
      // redirect and privilege for the current inputs
      t_now = trap_req ? (mret ? "R8" : "R6") : (mret ? "R7" : "R11");
      chk(redirect_valid == (trap_req | mret), t_now, "redirect_valid",
          32'(redirect_valid), 32'(trap_req | mret));
      if (trap_req) begin
         base   = mtvec & ~32'd3;
         exp_pc = (mtvec[1:0] == 2'd1 && trap_is_irq) ? base + 4 * trap_cause : base;
         chk(redirect_pc == exp_pc, t_now, "redirect_pc", redirect_pc, exp_pc);
         chk(priv_out == 2'd3, "R2", "priv_out", 32'(priv_out), 32'd3);
      end else if (mret) begin
         chk(redirect_pc == m_epc, "R7", "redirect_pc", redirect_pc, m_epc);
         chk(priv_out == m_mpp, "R7", "priv_out", 32'(priv_out), 32'(m_mpp));
      end else begin
         chk(priv_out == cur_priv, "R11", "priv_out", 32'(priv_out), 32'(cur_priv));
      end
      // interrupt request
      act_en   = irq_pend & irq_en;
      hit_e    = act_en[11];
      hit_s    = act_en[3];
      hit_t    = act_en[7];
      exp_take = m_mie && (hit_e || hit_s || hit_t);
      chk(irq_take == exp_take, "R9", "irq_take", 32'(irq_take), 32'(exp_take));
      if (exp_take) begin
         exp_code = hit_e ? 11 : (hit_s ? 3 : 7);
         chk(irq_code == CAUSE_W'(exp_code), "R10", "irq_code", 32'(irq_code), 32'(exp_code));
      end
   endtask

   task automatic update_model();
      if (!rst_n) begin
         m_mie = 0; m_mpie = 0; m_mpp = 2'd3;
         m_epc = 0; m_cause = 0; m_tval = 0;
         last_tag = "R1";
      end else if (trap_req) begin
         m_mpie  = m_mie;
         m_mie   = 0;
         m_mpp   = cur_priv;
         m_epc   = trap_pc & ~32'd1;
         m_cause = {trap_is_irq, 26'd0, trap_cause};
         m_tval  = trap_is_irq ? 32'd0 : trap_val;
         last_tag = "R2";
      end else if (mret) begin
         m_mie  = m_mpie;
         m_mpie = 1;
         m_mpp  = 2'd0;
         last_tag = "R7";
      end else begin
         last_tag = "R11";
      end
   endtask

   // one cycle: inputs already driven after a falling edge
   task automatic step();
      #1;
      if (rst_n) compare();
      @(posedge clk);
      update_model();
      @(negedge clk);
   endtask

   task automatic idle();
      trap_req = 0; mret = 0;
   endtask

   task automatic do_trap(input bit irq, input int cause, input logic [31:0] val,
                          input logic [31:0] pc, input logic [1:0] prv);
      trap_req = 1; mret = 0; trap_is_irq = irq;
      trap_cause = CAUSE_W'(cause); trap_val = val; trap_pc = pc; cur_priv = prv;
      step();
      idle();
   endtask

   task automatic do_mret();
      trap_req = 0; mret = 1;
      step();
      idle();
   endtask

   initial begin
      rst_n = 0; idle(); trap_is_irq = 0; trap_cause = '0; trap_val = '0;
      trap_pc = '0; cur_priv = 2'd3; mtvec = 32'h8000_0100;
      irq_pend = '0; irq_en = '0;
      @(negedge clk);
      step(); step();
      rst_n = 1;
      // R1 reset values seen in the first checked cycle
      step();
      // R9 pending and enabled but global enable clear
      irq_pend = 32'h0000_0888; irq_en = 32'hFFFF_FFFF; step();
      // exception from user mode, direct vector, odd pc
      do_trap(0, 2, 32'hDEAD_BEEF, 32'h0000_1001, 2'd0); step();
      // two returns: second one turns the global enable on
      cur_priv = 2'd3;
      do_mret(); step();
      do_mret(); step();
      // R10 priority patterns
      irq_pend = 32'h0000_0088; step();
      irq_pend = 32'h0000_0080; step();
      irq_pend = 32'h0000_0888; step();
      irq_pend = 32'h0000_0808; step();
      // R9 other bit positions ignored
      irq_pend = 32'hFFFF_F777; step();
      irq_pend = 32'h0000_0800; irq_en = 32'hFFFF_F7FF; step();
      // interrupt into vectored table, trap value zeroed
      irq_en = 32'hFFFF_FFFF; mtvec = 32'h8000_0201;
      do_trap(1, 7, 32'h0000_0055, 32'h0000_2004, 2'd3); step();
      // exception with vectored mode goes to base
      do_trap(0, 11, 32'h0000_0000, 32'h0000_3000, 2'd3); step();
      // reserved modes act as direct
      mtvec = 32'h8000_0302; do_trap(1, 11, 32'h1, 32'h0000_4002, 2'd0);
      mtvec = 32'h8000_0403; do_trap(1, 3, 32'h1, 32'h0000_4006, 2'd3);
      // R8 trap and return together
      mtvec = 32'h8000_0201;
      trap_req = 1; mret = 1; trap_is_irq = 1; trap_cause = 5'd11;
      trap_pc = 32'h0000_5000; cur_priv = 2'd0; step(); idle(); step();
      do_mret(); do_mret(); step();
      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         logic [3:0] r;
         r = 4'($urandom);
         trap_req    = (r[1:0] == 2'd0);
         mret        = (r[3:2] == 2'd0);
         trap_is_irq = 1'($urandom);
         trap_cause  = CAUSE_W'($urandom);
         trap_val    = $urandom;
         trap_pc     = $urandom;
         cur_priv    = 1'($urandom) ? 2'd3 : 2'd0;
         mtvec       = $urandom;
         irq_pend    = $urandom;
         irq_en      = $urandom;
         step();
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule